// File: doc/BRIEF.md
# Exception Entry Unit

This unit performs the state changes that a small processor core makes when it takes an exception. The core raises a one-cycle request with a 3-bit exception kind: privileged call, instruction abort, data abort or interrupt. The unit works out the processor mode that the kind leads to and switches the per-mode banked copies of two general registers (register 29 and register 30) and of the saved status word. It then builds the new status word and sends the program counter to a vector address.

The core presents its current status word, program counter, register 29, register 30 and saved status on the input side. The unit returns the values that those five architectural items take after entry, together with a one-cycle done pulse. The core writes these values back into its own state. The unit keeps the banks itself: one bank of three words for each of the four known modes. A control bit chooses between a low and a high vector table. A request that names an unknown kind, or that arrives while the status word holds an unknown mode code, raises an error pulse and changes nothing.

Top module: `exc_entry_unit`

## Requirements
- R1: Kind code 0 (privileged call) enters mode 5'h13. Kind codes 1 (instruction abort) and 2 (data abort) both enter mode 5'h17. Kind code 3 (interrupt) enters mode 5'h12. The mode entered appears in status_o[4:0].
- R2: After an entry, status_o is the sampled cur_status_i with bits [4:0] replaced by the mode entered and bit 7 (interrupt disable) set. Every other bit is copied unchanged.
- R3: After an entry, sst_o holds the complete sampled cur_status_i, including its old mode field.
- R4: After an entry, r30_o holds the sampled cur_pc_i.
- R5: After an entry, pc_o equals base + 4 * kind. The base is 0x00000000 when sys_ctrl_i[13] is 0 and 0xFFFF0000 when it is 1. No other bit of sys_ctrl_i has any effect.
- R6: Each known mode owns a bank of three words: register 29, register 30 and saved status. The known modes are 5'h10 (user), 5'h12, 5'h13 and 5'h17. When the mode entered differs from the current mode, cur_r29_i, cur_r30_i and cur_sst_i are stored into the current mode's bank, and r29_o takes the register-29 word of the entered mode's bank. r30_o and sst_o still take their entry values from R3 and R4.
- R7: When the mode entered equals the current mode, no bank is written and r29_o equals the sampled cur_r29_i.
- R8: A request with kind 4 to 7, or with cur_status_i[4:0] not a known mode, pulses err_o for one cycle with done_o low. Each output takes its sampled input unchanged (status_o, pc_o, r29_o, r30_o, sst_o from cur_status_i, cur_pc_i, cur_r29_i, cur_r30_i, cur_sst_i). No bank is written.
- R9: A request is sampled at a rising edge, and its outputs and a one-cycle done_o pulse appear after that same edge. Requests on consecutive cycles are each handled. Without a request, every output holds and done_o and err_o stay low.
- R10: The synchronous reset clears every output, clears done_o and err_o, and clears all bank words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Exception request, sampled each rising edge |
| kind_i | input | 3 | Exception kind code |
| sys_ctrl_i | input | 32 | System control word; bit 13 selects the high vector base |
| cur_status_i | input | 32 | Current status word; bits [4:0] hold the mode |
| cur_pc_i | input | 32 | Current program counter |
| cur_r29_i | input | 32 | Current register 29 |
| cur_r30_i | input | 32 | Current register 30 |
| cur_sst_i | input | 32 | Current saved status word |
| status_o | output | 32 | Status word after entry |
| pc_o | output | 32 | Program counter after entry |
| r29_o | output | 32 | Register 29 after entry |
| r30_o | output | 32 | Register 30 after entry |
| sst_o | output | 32 | Saved status word after entry |
| done_o | output | 1 | One-cycle pulse for a completed entry |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
Two things share one clock edge. The first is storing the old mode's bank while the register-29 word is read from the new mode's bank. The second is that a bank written on one edge can be read on the very next edge. The bench provokes both with back-to-back requests. One request goes from privileged mode into trap mode, and the next, in the following cycle, goes from trap back into privileged mode. r29_o must then show the word stored into the privileged bank one cycle earlier. A behavioural model holds the banks as plain arrays and is compared on every clock. Error requests are followed by an entry into the mode whose bank they could have corrupted, so that the bank contents show up at the ports.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int MODE_W     = 5;
   localparam int NUM_BANKS  = 4;
   localparam int BANK_IDX_W = $clog2(NUM_BANKS);
   localparam int NUM_KINDS  = 4;
   localparam int SLOT_W     = $clog2(NUM_KINDS);

   typedef logic [MODE_W-1:0]     mode_t;
   typedef logic [BANK_IDX_W-1:0] bank_idx_t;

   localparam mode_t MODE_USER = 5'h10;
   localparam mode_t MODE_INTR = 5'h12;
   localparam mode_t MODE_PRIV = 5'h13;
   localparam mode_t MODE_TRAP = 5'h17;

   typedef enum logic [2:0] {
      KIND_PCALL = 3'd0,
      KIND_IABT  = 3'd1,
      KIND_DABT  = 3'd2,
      KIND_IRQ   = 3'd3
   } exc_kind_e;

   typedef struct packed {
      logic      ok;
      bank_idx_t idx;
   } mode_info_t;

endpackage

// File: rtl/exc_mode_decode.sv
module exc_mode_decode
   import exc_entry_pkg::*;
(
   input  mode_t      mode_i,
   output mode_info_t info_o
);

   always_comb begin
      info_o = '{ok: 1'b1, idx: '0};
      unique case (mode_i)
         MODE_USER: info_o.idx = bank_idx_t'(0);
         MODE_INTR: info_o.idx = bank_idx_t'(1);
         MODE_PRIV: info_o.idx = bank_idx_t'(2);
         MODE_TRAP: info_o.idx = bank_idx_t'(3);
         default:   info_o     = '{ok: 1'b0, idx: '0};
      endcase
   end

endmodule

// File: rtl/exc_kind_map.sv
module exc_kind_map
   import exc_entry_pkg::*;
#(
   parameter int KIND_W = 3
) (
   input  logic [KIND_W-1:0] kind_i,
   output logic              ok_o,
   output mode_t             tgt_o,
   output logic [SLOT_W-1:0] slot_o
);

   always_comb begin
      ok_o   = 1'b1;
      tgt_o  = MODE_PRIV;
      slot_o = kind_i[SLOT_W-1:0];
      if (kind_i >= KIND_W'(NUM_KINDS)) begin
         ok_o = 1'b0;
      end else begin
         unique case (exc_kind_e'(3'(kind_i)))
            KIND_PCALL: tgt_o = MODE_PRIV;
            KIND_IABT:  tgt_o = MODE_TRAP;
            KIND_DABT:  tgt_o = MODE_TRAP;
            KIND_IRQ:   tgt_o = MODE_INTR;
            default:    ok_o  = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_entry_pkg::*;
#(
   parameter int              DATA_W     = 32,
   parameter logic [DATA_W-1:0] LO_VEC   = '0,
   parameter logic [DATA_W-1:0] HI_VEC   = 32'hFFFF_0000,
   parameter int              VEC_STRIDE = 4
) (
   input  logic              hi_sel_i,
   input  logic [SLOT_W-1:0] slot_i,
   output logic [DATA_W-1:0] addr_o
);

   localparam bit STRIDE_POW2 = (VEC_STRIDE & (VEC_STRIDE - 1)) == 0;
   localparam int STRIDE_SH   = $clog2(VEC_STRIDE);

   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] offs;

   assign base = hi_sel_i ? HI_VEC : LO_VEC;

   generate
      if (STRIDE_POW2) begin : g_shift
         assign offs = DATA_W'(slot_i) << STRIDE_SH;
      end else begin : g_mult
         assign offs = DATA_W'(slot_i) * DATA_W'(VEC_STRIDE);
      end
   endgenerate

   assign addr_o = base + offs;

endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file #(
   parameter int DATA_W = 32,
   parameter int NB     = 4,
   parameter int IDX_W  = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] w29_i,
   input  logic [DATA_W-1:0] w30_i,
   input  logic [DATA_W-1:0] wsst_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [DATA_W-1:0] r29_o,
   output logic [DATA_W-1:0] r30_o,
   output logic [DATA_W-1:0] rsst_o
);

   localparam int FLAT_W = NB * DATA_W;

   logic [FLAT_W-1:0] flat29;
   logic [FLAT_W-1:0] flat30;
   logic [FLAT_W-1:0] flatsst;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         logic [DATA_W-1:0] q29;
         logic [DATA_W-1:0] q30;
         logic [DATA_W-1:0] qsst;
         logic              hit;

         assign hit = we_i && (widx_i == IDX_W'(b));

         always_ff @(posedge clk) begin
            if (rst) begin
               q29  <= '0;
               q30  <= '0;
               qsst <= '0;
            end else if (hit) begin
               q29  <= w29_i;
               q30  <= w30_i;
               qsst <= wsst_i;
            end
         end

         assign flat29[b*DATA_W +: DATA_W]  = q29;
         assign flat30[b*DATA_W +: DATA_W]  = q30;
         assign flatsst[b*DATA_W +: DATA_W] = qsst;
      end
   endgenerate

   assign r29_o  = flat29[int'(ridx_i)*DATA_W +: DATA_W];
   assign r30_o  = flat30[int'(ridx_i)*DATA_W +: DATA_W];
   assign rsst_o = flatsst[int'(ridx_i)*DATA_W +: DATA_W];

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                KIND_W      = 3,
   parameter int                IRQ_DIS_POS = 7,
   parameter int                VSEL_POS    = 13,
   parameter logic [DATA_W-1:0] LO_VEC      = '0,
   parameter logic [DATA_W-1:0] HI_VEC      = 32'hFFFF_0000,
   parameter int                VEC_STRIDE  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic [KIND_W-1:0] kind_i,
   input  logic [DATA_W-1:0] sys_ctrl_i,
   input  logic [DATA_W-1:0] cur_status_i,
   input  logic [DATA_W-1:0] cur_pc_i,
   input  logic [DATA_W-1:0] cur_r29_i,
   input  logic [DATA_W-1:0] cur_r30_i,
   input  logic [DATA_W-1:0] cur_sst_i,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] pc_o,
   output logic [DATA_W-1:0] r29_o,
   output logic [DATA_W-1:0] r30_o,
   output logic [DATA_W-1:0] sst_o,
   output logic              done_o,
   output logic              err_o
);

   // elaboration-time parameter checks
   generate
      if (DATA_W < MODE_W + 1) begin : g_bad_width
         $error("DATA_W too narrow for mode field");
      end
      if (IRQ_DIS_POS < MODE_W || IRQ_DIS_POS >= DATA_W) begin : g_bad_irq
         $error("IRQ_DIS_POS must sit above the mode field");
      end
      if (VSEL_POS < 0 || VSEL_POS >= DATA_W) begin : g_bad_vsel
         $error("VSEL_POS outside the control word");
      end
      if (VEC_STRIDE < 1) begin : g_bad_stride
         $error("VEC_STRIDE must be positive");
      end
      if ((1 << KIND_W) < NUM_KINDS || KIND_W > 3) begin : g_bad_kind
         $error("KIND_W must cover the kind codes");
      end
   endgenerate

   mode_info_t        cur_info;
   mode_info_t        tgt_info;
   mode_t             tgt_mode;
   logic              kind_ok;
   logic [SLOT_W-1:0] slot;
   logic [DATA_W-1:0] vec_addr;
   logic              entry_ok;
   logic              mode_same;
   logic              bank_we;
   logic [DATA_W-1:0] bank_r29;
   logic [DATA_W-1:0] bank_r30;
   logic [DATA_W-1:0] bank_sst;
   logic [DATA_W-1:0] status_n;
   logic [DATA_W-1:0] r29_n;
   logic [DATA_W-1:0] r30_n;
   logic [DATA_W-1:0] sst_n;
   logic              unused_ctrl;

   assign unused_ctrl = ^(sys_ctrl_i & ~(DATA_W'(1) << VSEL_POS));

   exc_kind_map #(.KIND_W(KIND_W)) u_kind (
      .kind_i (kind_i),
      .ok_o   (kind_ok),
      .tgt_o  (tgt_mode),
      .slot_o (slot)
   );

   exc_mode_decode u_cur_dec (
      .mode_i (cur_status_i[MODE_W-1:0]),
      .info_o (cur_info)
   );

   exc_mode_decode u_tgt_dec (
      .mode_i (tgt_mode),
      .info_o (tgt_info)
   );

   exc_vector_gen #(
      .DATA_W     (DATA_W),
      .LO_VEC     (LO_VEC),
      .HI_VEC     (HI_VEC),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_vec (
      .hi_sel_i (sys_ctrl_i[VSEL_POS]),
      .slot_i   (slot),
      .addr_o   (vec_addr)
   );

   assign entry_ok  = kind_ok && cur_info.ok && tgt_info.ok;
   assign mode_same = (cur_info.idx == tgt_info.idx);
   assign bank_we   = req_i && entry_ok && !mode_same;

   exc_bank_file #(
      .DATA_W (DATA_W),
      .NB     (NUM_BANKS),
      .IDX_W  (BANK_IDX_W)
   ) u_banks (
      .clk    (clk),
      .rst    (rst),
      .we_i   (bank_we),
      .widx_i (cur_info.idx),
      .w29_i  (cur_r29_i),
      .w30_i  (cur_r30_i),
      .wsst_i (cur_sst_i),
      .ridx_i (tgt_info.idx),
      .r29_o  (bank_r29),
      .r30_o  (bank_r30),
      .rsst_o (bank_sst)
   );

   // restore from the new bank, then apply the entry updates on top
   always_comb begin
      if (mode_same) begin
         r29_n = cur_r29_i;
         r30_n = cur_r30_i;
         sst_n = cur_sst_i;
      end else begin
         r29_n = bank_r29;
         r30_n = bank_r30;
         sst_n = bank_sst;
      end
      r30_n = cur_pc_i;
      sst_n = cur_status_i;
      status_n = cur_status_i;
      status_n[MODE_W-1:0]  = tgt_mode;
      status_n[IRQ_DIS_POS] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         status_o <= '0;
         pc_o     <= '0;
         r29_o    <= '0;
         r30_o    <= '0;
         sst_o    <= '0;
         done_o   <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (req_i) begin
            if (entry_ok) begin
               done_o   <= 1'b1;
               status_o <= status_n;
               pc_o     <= vec_addr;
               r29_o    <= r29_n;
               r30_o    <= r30_n;
               sst_o    <= sst_n;
            end else begin
               err_o    <= 1'b1;
               status_o <= cur_status_i;
               pc_o     <= cur_pc_i;
               r29_o    <= cur_r29_i;
               r30_o    <= cur_r30_i;
               sst_o    <= cur_sst_i;
            end
         end
      end
   end

endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk
   import exc_entry_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                KIND_W      = 3,
   parameter int                IRQ_DIS_POS = 7,
   parameter logic [DATA_W-1:0] LO_VEC      = '0,
   parameter logic [DATA_W-1:0] HI_VEC      = 32'hFFFF_0000,
   parameter int                VEC_STRIDE  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              req_i,
   input logic [KIND_W-1:0] kind_i,
   input logic              hi_sel_i,
   input logic [DATA_W-1:0] cur_status_i,
   input logic [DATA_W-1:0] cur_pc_i,
   input logic [DATA_W-1:0] cur_r29_i,
   input logic [DATA_W-1:0] cur_r30_i,
   input logic [DATA_W-1:0] cur_sst_i,
   input logic [DATA_W-1:0] status_o,
   input logic [DATA_W-1:0] pc_o,
   input logic [DATA_W-1:0] r29_o,
   input logic [DATA_W-1:0] r30_o,
   input logic [DATA_W-1:0] sst_o,
   input logic              done_o,
   input logic              err_o
);

   logic              c_ok;
   mode_t             c_tgt;
   logic [DATA_W-1:0] c_vec;
   logic              c_known;

   always_comb begin
      c_known = (cur_status_i[MODE_W-1:0] == MODE_USER) ||
                (cur_status_i[MODE_W-1:0] == MODE_INTR) ||
                (cur_status_i[MODE_W-1:0] == MODE_PRIV) ||
                (cur_status_i[MODE_W-1:0] == MODE_TRAP);
      c_ok    = c_known && (kind_i < KIND_W'(NUM_KINDS));
      c_tgt   = (kind_i == KIND_W'(0)) ? MODE_PRIV :
                (kind_i == KIND_W'(3)) ? MODE_INTR : MODE_TRAP;
      c_vec   = (hi_sel_i ? HI_VEC : LO_VEC) +
                DATA_W'(VEC_STRIDE) * DATA_W'(kind_i);
   end

   a_r9_done_follows_req: assert property (@(posedge clk) disable iff (rst)
      (req_i && c_ok) |=> (done_o && !err_o));

   a_r8_err_on_bad_req: assert property (@(posedge clk) disable iff (rst)
      (req_i && !c_ok) |=> (err_o && !done_o));

   a_r9_quiet_idle: assert property (@(posedge clk) disable iff (rst)
      !req_i |=> (!done_o && !err_o && $stable(status_o) && $stable(pc_o) &&
                  $stable(r29_o)));

   a_r1_mode_entered: assert property (@(posedge clk) disable iff (rst)
      (req_i && c_ok) |=> (status_o[MODE_W-1:0] == $past(c_tgt)));

   a_r2_irq_disabled: assert property (@(posedge clk) disable iff (rst)
      done_o |-> status_o[IRQ_DIS_POS]);

   a_r3_saved_status: assert property (@(posedge clk) disable iff (rst)
      (req_i && c_ok) |=> (sst_o == $past(cur_status_i)));

   a_r4_link_gets_pc: assert property (@(posedge clk) disable iff (rst)
      (req_i && c_ok) |=> (r30_o == $past(cur_pc_i)));

   a_r5_vector: assert property (@(posedge clk) disable iff (rst)
      (req_i && c_ok) |=> (pc_o == $past(c_vec)));

   a_r7_same_mode_r29: assert property (@(posedge clk) disable iff (rst)
      (req_i && c_ok && (c_tgt == cur_status_i[MODE_W-1:0])) |=>
      (r29_o == $past(cur_r29_i)));

   a_r8_state_kept: assert property (@(posedge clk) disable iff (rst)
      (req_i && !c_ok) |=> (status_o == $past(cur_status_i) &&
                            pc_o == $past(cur_pc_i) &&
                            r29_o == $past(cur_r29_i) &&
                            r30_o == $past(cur_r30_i) &&
                            sst_o == $past(cur_sst_i)));

   a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(done_o && err_o));

endmodule

bind exc_entry_unit exc_entry_unit_chk #(
   .DATA_W      (DATA_W),
   .KIND_W      (KIND_W),
   .IRQ_DIS_POS (IRQ_DIS_POS),
   .LO_VEC      (LO_VEC),
   .HI_VEC      (HI_VEC),
   .VEC_STRIDE  (VEC_STRIDE)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .req_i        (req_i),
   .kind_i       (kind_i),
   .hi_sel_i     (sys_ctrl_i[VSEL_POS]),
   .cur_status_i (cur_status_i),
   .cur_pc_i     (cur_pc_i),
   .cur_r29_i    (cur_r29_i),
   .cur_r30_i    (cur_r30_i),
   .cur_sst_i    (cur_sst_i),
   .status_o     (status_o),
   .pc_o         (pc_o),
   .r29_o        (r29_o),
   .r30_o        (r30_o),
   .sst_o        (sst_o),
   .done_o       (done_o),
   .err_o        (err_o)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0;
   logic [2:0]  kind = '0;
   logic [31:0] sys_ctrl = '0;
   logic [31:0] cur_status = '0, cur_pc = '0, cur_r29 = '0, cur_r30 = '0, cur_sst = '0;
   logic [31:0] status_o, pc_o, r29_o, r30_o, sst_o;
   logic        done_o, err_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit cmp_en  = 1'b0;

   // bench-owned architectural state fed into each request
   logic [31:0] fb_status, fb_pc, fb_r29, fb_r30, fb_sst;

   // reference model
   logic [31:0] m_status = '0, m_pc = '0, m_r29 = '0, m_r30 = '0, m_sst = '0;
   logic        m_done = 1'b0, m_err = 1'b0;
   logic [31:0] b29 [4];
   logic [31:0] b30 [4];
   logic [31:0] bsst[4];

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_unit u_dut (
      .clk(clk), .rst(rst), .req_i(req), .kind_i(kind), .sys_ctrl_i(sys_ctrl),
      .cur_status_i(cur_status), .cur_pc_i(cur_pc), .cur_r29_i(cur_r29),
      .cur_r30_i(cur_r30), .cur_sst_i(cur_sst),
      .status_o(status_o), .pc_o(pc_o), .r29_o(r29_o), .r30_o(r30_o),
      .sst_o(sst_o), .done_o(done_o), .err_o(err_o)
   );

   function automatic int bank_of(input logic [4:0] m);
      case (m)
         5'h10: return 0;
         5'h12: return 1;
         5'h13: return 2;
         5'h17: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic logic [4:0] target_of(input logic [2:0] k);
      case (k)
         3'd0: return 5'h13;
         3'd1, 3'd2: return 5'h17;
         default: return 5'h12;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_status = '0; m_pc = '0; m_r29 = '0; m_r30 = '0; m_sst = '0;
         m_done = 1'b0; m_err = 1'b0;
         for (int b = 0; b < 4; b++) begin b29[b] = '0; b30[b] = '0; bsst[b] = '0; end
      end else begin
         m_done = 1'b0;
         m_err  = 1'b0;
         if (req) begin
            int ci, ti;
            ci = bank_of(cur_status[4:0]);
            ti = bank_of(target_of(kind));
            if (kind > 3'd3 || ci < 0) begin
               m_err = 1'b1;
               m_status = cur_status; m_pc = cur_pc; m_r29 = cur_r29;
               m_r30 = cur_r30; m_sst = cur_sst;
            end else begin
               m_done = 1'b1;
               if (ci != ti) begin
                  m_r29 = b29[ti];
                  b29[ci] = cur_r29; b30[ci] = cur_r30; bsst[ci] = cur_sst;
               end else begin
                  m_r29 = cur_r29;
               end
               m_r30 = cur_pc;
               m_sst = cur_status;
               m_status = {cur_status[31:8], 1'b1, cur_status[6:5], target_of(kind)};
               m_pc = (sys_ctrl[13] ? 32'hFFFF_0000 : 32'h0) + 32'(kind) * 32'd4;
               fb_status = m_status; fb_pc = m_pc; fb_r29 = m_r29;
               fb_r30 = m_r30; fb_sst = m_sst;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // compare against the model on every clock, away from the rising edge
   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R1/R2 status_o vs model", status_o, m_status);
         chk("R5 pc_o vs model", pc_o, m_pc);
         chk("R6/R7 r29_o vs model", r29_o, m_r29);
         chk("R4 r30_o vs model", r30_o, m_r30);
         chk("R3 sst_o vs model", sst_o, m_sst);
         chk("R9 done_o vs model", 32'(done_o), 32'(m_done));
         chk("R8 err_o vs model", 32'(err_o), 32'(m_err));
      end
   end

   task automatic issue(input logic [2:0] k, input logic hi);
      req = 1'b1;
      kind = k;
      sys_ctrl = (hi ? 32'h0000_2000 : 32'h0) | 32'h0000_1005;
      cur_status = fb_status; cur_pc = fb_pc; cur_r29 = fb_r29;
      cur_r30 = fb_r30; cur_sst = fb_sst;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic idle(input int n);
      req = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog expired act=%0d exp=%0d", WD_CYCLES, 0);
      finish_run();
   end

   initial begin
      fb_status = 32'h0000_0010; fb_pc = 32'h1000_0040; fb_r29 = 32'hAAAA_0001;
      fb_r30 = 32'h0; fb_sst = 32'h0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 status_o reset", status_o, 32'h0);
      chk("R10 pc_o reset", pc_o, 32'h0);
      chk("R10 r29_o reset", r29_o, 32'h0);
      chk("R10 done_o/err_o reset", {30'h0, done_o, err_o}, 32'h0);
      rst = 1'b0;
      cmp_en = 1'b1;
      idle(2);

      // user -> privileged, low vectors
      issue(3'd0, 1'b0);
      chk("R1 pcall enters 5'h13", 32'(status_o[4:0]), 32'h13);
      chk("R2 status with I set", status_o, 32'h0000_0093);
      chk("R5 low vector slot 0", pc_o, 32'h0);
      chk("R4 r30_o takes pc", r30_o, 32'h1000_0040);
      chk("R3 sst_o takes old status", sst_o, 32'h0000_0010);
      chk("R6 empty privileged bank", r29_o, 32'h0);
      chk("R9 done pulse", 32'(done_o), 32'h1);

      // privileged -> trap, then trap -> privileged in the next cycle
      fb_r29 = 32'h5050_0002; fb_pc = 32'h0000_0100;
      issue(3'd1, 1'b0);
      chk("R1 iabt enters 5'h17", 32'(status_o[4:0]), 32'h17);
      chk("R5 low vector slot 1", pc_o, 32'h4);
      issue(3'd0, 1'b1);
      chk("R6 r29 restored back-to-back", r29_o, 32'h5050_0002);
      chk("R5 high vector slot 0", pc_o, 32'hFFFF_0000);
      chk("R4 r30_o after back-to-back", r30_o, 32'h4);
      chk("R9 done on consecutive request", 32'(done_o), 32'h1);

      // idle holds
      idle(3);
      chk("R9 outputs hold while idle", pc_o, 32'hFFFF_0000);
      chk("R9 done low while idle", 32'(done_o), 32'h0);

      // same mode entry
      fb_r29 = 32'h1234_5678;
      issue(3'd0, 1'b0);
      chk("R7 same mode keeps r29", r29_o, 32'h1234_5678);

      // interrupt with high vectors
      issue(3'd3, 1'b1);
      chk("R1 irq enters 5'h12", 32'(status_o[4:0]), 32'h12);
      chk("R5 high vector slot 3", pc_o, 32'hFFFF_000C);

      // unknown kind while in interrupt mode
      fb_r29 = 32'hDEAD_BEEF;
      issue(3'd5, 1'b0);
      chk("R8 err on unknown kind", 32'(err_o), 32'h1);
      chk("R8 r29_o passes input", r29_o, 32'hDEAD_BEEF);
      chk("R8 no done on error", 32'(done_o), 32'h0);

      // unknown mode code
      fb_status = 32'h0000_009F;
      issue(3'd0, 1'b0);
      chk("R8 err on unknown mode", 32'(err_o), 32'h1);
      chk("R8 status_o unchanged", status_o, 32'h0000_009F);

      // enter interrupt mode from trap: bank must be untouched by errors
      fb_status = 32'h0000_0017;
      issue(3'd3, 1'b0);
      chk("R8 interrupt bank untouched by errors", r29_o, 32'h0);
      chk("R5 low vector slot 3", pc_o, 32'h0000_000C);

      // data abort from trap mode: same mode
      fb_status = 32'hA5A5_0017; fb_r29 = 32'h0F0F_0F0F;
      issue(3'd2, 1'b0);
      chk("R7 dabt in trap mode keeps r29", r29_o, 32'h0F0F_0F0F);
      chk("R2 upper status bits kept", status_o, 32'hA5A5_0097);

      // random stream, compared every cycle
      for (int i = 0; i < 400; i++) begin
         logic [2:0] k;
         if ($urandom_range(0, 9) == 0) fb_status[4:0] = 5'($urandom);
         else if (bank_of(fb_status[4:0]) < 0) begin
            case ($urandom_range(0, 3))
               0: fb_status[4:0] = 5'h10;
               1: fb_status[4:0] = 5'h12;
               2: fb_status[4:0] = 5'h13;
               default: fb_status[4:0] = 5'h17;
            endcase
         end
         if ($urandom_range(0, 3) == 0) fb_r29 = $urandom;
         if ($urandom_range(0, 3) == 0) fb_pc = $urandom;
         if ($urandom_range(0, 5) == 0) fb_status[31:8] = 24'($urandom);
         k = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
         issue(k, 1'($urandom_range(0, 1)));
         if ($urandom_range(0, 3) == 0) idle(1);
      end

      // second reset clears the banks
      rst = 1'b1;
      idle(2);
      chk("R10 outputs cleared by reset", status_o | pc_o | r29_o, 32'h0);
      rst = 1'b0;
      fb_status = 32'h0000_0010; fb_r29 = 32'h3333_3333;
      issue(3'd0, 1'b0);
      chk("R10 privileged bank cleared", r29_o, 32'h0);
      idle(2);
      finish_run();
   end

endmodule